// File: doc/BRIEF.md
# Precise Pipeline Exception Controller

This block takes exception requests from a five-stage in-order pipeline and turns them into a precise trap. Two stages can raise a request. The decode stage raises one for an undefined opcode, and the execute stage raises one for an arithmetic overflow. Each request comes with the PC of the instruction that raised it. When requests appear, the block picks the one from the oldest instruction in program order, and an execute-stage instruction is always older than a decode-stage one.

In the same cycle, the block clears the control fields of the faulting instruction's pipeline register and of every pipeline register that holds a younger instruction. It also blocks the register write-back of a faulting instruction in execute, and it steers fetch to a fixed handler entry address. Instructions already in the memory or write-back stage are older than the fault, so they are left to finish.

On the following clock edge the block loads two registers. The exception PC register receives the faulting PC plus one instruction step, and the handler must adjust this value. The one-bit cause register receives the cause code. All pins are plain control and status signals. No data stream passes through the block, so no port carries a valid/ready handshake and there is no back-pressure.

Top module: `pipe_exc_ctrl`

## Requirements
- R1: While `rst_n` is low and after it rises, `epc` reads 0, `cause` reads 0, `flush_vec` is 0, `wb_kill` is 0 and `redirect_valid` is 0, until the first exception is taken.
- R2: When `ex_valid` and `ex_ovf` are both high, in the same cycle `flush_vec` equals 3'b111, `wb_kill` is 1, `redirect_valid` is 1 and `redirect_pc` equals `HANDLER_PC` (default 32'h8000_0180). The bit positions of `flush_vec` are: bit 0 for IF/ID, bit 1 for ID/EX, bit 2 for EX/MEM.
- R3: When `id_valid` and `id_undef` are both high and no execute overflow is taken, in the same cycle `flush_vec` equals 3'b011, `wb_kill` is 0, and `redirect_valid` is 1 with `redirect_pc` equal to `HANDLER_PC`. The EX/MEM register (bit 2) is not flushed, because the instruction it receives is older than the fault.
- R4: When both stages request in the same cycle, the execute overflow is serviced. The outputs follow R2, and on the next edge `cause` becomes 1 and `epc` becomes `ex_pc`+4.
- R5: On the clock edge that ends a cycle in which an exception is taken, `epc` loads the faulting PC plus `PC_STEP` (default 4), with wrap-around modulo 2^32. In the same edge `cause` loads the cause code: 0 means undefined opcode and 1 means overflow.
- R6: In any cycle in which no exception is taken, `epc` and `cause` keep their values across the clock edge.
- R7: An `id_undef` flag while `id_valid` is low, or an `ex_ovf` flag while `ex_valid` is low, has no effect. `flush_vec` stays 0, `wb_kill` and `redirect_valid` stay 0, and `epc` and `cause` are unchanged on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode stage holds a live instruction |
| id_undef | input | 1 | Decode stage reports an undefined opcode |
| id_pc | input | 32 | PC of the decode-stage instruction |
| ex_valid | input | 1 | Execute stage holds a live instruction |
| ex_ovf | input | 1 | Execute stage reports arithmetic overflow |
| ex_pc | input | 32 | PC of the execute-stage instruction |
| flush_vec | output | 3 | Clear control fields: bit0 IF/ID, bit1 ID/EX, bit2 EX/MEM |
| wb_kill | output | 1 | Suppress register write-back of the execute-stage instruction |
| redirect_valid | output | 1 | Steer fetch to `redirect_pc` this cycle |
| redirect_pc | output | 32 | Handler entry address |
| epc | output | 32 | Exception PC register (faulting PC + step) |
| cause | output | 1 | Cause register: 0 undefined opcode, 1 overflow |

## Verification
The bench builds the block with its default parameters: a 32-bit PC, a step of 4 and a handler address of 32'h8000_0180. These values put the PC wrap-around at 32'hFFFF_FFFC within reach, and with them the exact handler address on the redirect port can be compared against a known constant. A pseudo-random stream of valid and flag combinations covers simultaneous requests, flags without valid, and back-to-back exceptions. These patterns exercise the priority between the two stages and the holding of EPC and Cause between traps.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic {
    CAUSE_UNDEF = 1'b0,
    CAUSE_OVF   = 1'b1
  } exc_cause_e;

  // pipeline registers that may be flushed, youngest first
  localparam int unsigned N_PREG   = 3;
  localparam int unsigned PREG_W   = $clog2(N_PREG);
  localparam int unsigned IFID_IX  = 0;
  localparam int unsigned IDEX_IX  = 1;
  localparam int unsigned EXMEM_IX = 2;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                id_valid,
  input  logic                id_undef,
  input  logic [XLEN-1:0]     id_pc,
  input  logic                ex_valid,
  input  logic                ex_ovf,
  input  logic [XLEN-1:0]     ex_pc,
  output logic                take,
  output exc_cause_e          take_cause,
  output logic [XLEN-1:0]     take_pc,
  output logic [PREG_W-1:0]   take_depth
);
  logic ex_hit, id_hit, id_sel;

  assign ex_hit = ex_valid && ex_ovf;
  assign id_hit = id_valid && id_undef;
  // execute holds the older instruction, so it wins
  assign id_sel = id_hit && !ex_hit;

  always_comb begin
    take       = ex_hit || id_hit;
    take_cause = CAUSE_UNDEF;
    take_pc    = '0;
    take_depth = '0;
    if (ex_hit) begin
      take_cause = CAUSE_OVF;
      take_pc    = ex_pc;
      take_depth = PREG_W'(EXMEM_IX);
    end else if (id_sel) begin
      take_cause = CAUSE_UNDEF;
      take_pc    = id_pc;
      take_depth = PREG_W'(IDEX_IX);
    end
  end

  // R4: at most one source selected, execute preferred
  a_r4_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ex_hit, id_sel}));
  a_r4_ex_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_ovf && id_valid && id_undef) |-> (take_cause == CAUSE_OVF && take_pc == ex_pc));
endmodule

// File: rtl/exc_flush_gen.sv
module exc_flush_gen
  import exc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [PREG_W-1:0] take_depth,
  output logic [N_PREG-1:0] flush_vec,
  output logic              wb_kill
);
  // flush every register from the fault's entry register back to fetch
  for (genvar k = 0; k < N_PREG; k++) begin : g_flush
    assign flush_vec[k] = take && (k <= int'(take_depth));
  end

  // faulting execute instruction loses its register write
  assign wb_kill = flush_vec[EXMEM_IX];

  // R2/R3: a flush is always contiguous from IF/ID
  a_r3_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_vec != '0) |-> flush_vec[IFID_IX] && flush_vec[IDEX_IX]);
  a_r7_no_take_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> (flush_vec == '0 && !wb_kill));
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned PC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  exc_cause_e      take_cause,
  input  logic [XLEN-1:0] take_pc,
  output logic [XLEN-1:0] epc_q,
  output exc_cause_e      cause_q
);
  localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= CAUSE_UNDEF;
    end else if (take) begin
      epc_q   <= take_pc + STEP;
      cause_q <= take_cause;
    end
  end

  // R6: registers hold when nothing is taken
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(epc_q) && $stable(cause_q)));
  // R5: load of faulting PC plus step
  a_r5_epc_load: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (epc_q == $past(take_pc) + STEP && cause_q == $past(take_cause)));
endmodule

// File: rtl/pipe_exc_ctrl.sv
module pipe_exc_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned     XLEN       = 32,
  parameter int unsigned     PC_STEP    = 4,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h8000_0180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid,
  input  logic              id_undef,
  input  logic [XLEN-1:0]   id_pc,
  input  logic              ex_valid,
  input  logic              ex_ovf,
  input  logic [XLEN-1:0]   ex_pc,
  output logic [N_PREG-1:0] flush_vec,
  output logic              wb_kill,
  output logic              redirect_valid,
  output logic [XLEN-1:0]   redirect_pc,
  output logic [XLEN-1:0]   epc,
  output logic              cause
);
  logic              take;
  exc_cause_e        take_cause;
  logic [XLEN-1:0]   take_pc;
  logic [PREG_W-1:0] take_depth;
  exc_cause_e        cause_q;

  exc_arbiter #(.XLEN(XLEN)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .id_valid(id_valid), .id_undef(id_undef), .id_pc(id_pc),
    .ex_valid(ex_valid), .ex_ovf(ex_ovf), .ex_pc(ex_pc),
    .take(take), .take_cause(take_cause), .take_pc(take_pc),
    .take_depth(take_depth)
  );

  exc_flush_gen u_flush (
    .clk(clk), .rst_n(rst_n),
    .take(take), .take_depth(take_depth),
    .flush_vec(flush_vec), .wb_kill(wb_kill)
  );

  exc_state_regs #(.XLEN(XLEN), .PC_STEP(PC_STEP)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .take(take), .take_cause(take_cause), .take_pc(take_pc),
    .epc_q(epc), .cause_q(cause_q)
  );

  assign cause          = cause_q;
  assign redirect_valid = take;
  assign redirect_pc    = HANDLER_PC;

  // R2: overflow in execute kills write-back and flushes all three registers
  a_r2_ovf_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_ovf) |-> (flush_vec == 3'b111 && wb_kill && redirect_valid));
  a_r3_kill_only_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    wb_kill |-> (ex_valid && ex_ovf));
  // R7: flags without valid do nothing
  a_r7_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ex_valid && ex_ovf) && !(id_valid && id_undef)) |-> (!redirect_valid && flush_vec == '0));
  a_r4_cause_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_ovf) |=> (cause == 1'b1 && epc == $past(ex_pc) + XLEN'(PC_STEP)));
endmodule

// File: tb/pipe_exc_ctrl_test.sv
`timescale 1ns/1ps
module pipe_exc_ctrl_test;
  localparam logic [31:0] HANDLER = 32'h8000_0180;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        id_valid = 0, id_undef = 0, ex_valid = 0, ex_ovf = 0;
  logic [31:0] id_pc = '0, ex_pc = '0;
  logic [2:0]  flush_vec;
  logic        wb_kill, redirect_valid, cause;
  logic [31:0] redirect_pc, epc;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_epc = '0;
  logic        m_cause = 1'b0;

  always #2.5 clk = ~clk;

  pipe_exc_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .id_valid(id_valid), .id_undef(id_undef), .id_pc(id_pc),
    .ex_valid(ex_valid), .ex_ovf(ex_ovf), .ex_pc(ex_pc),
    .flush_vec(flush_vec), .wb_kill(wb_kill),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .epc(epc), .cause(cause)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // apply one cycle of stimulus and compare against the reference
  task automatic step(input bit iv, input bit iu, input logic [31:0] ipc,
                      input bit ev, input bit eo, input logic [31:0] epc_in,
                      input string req);
    bit tk_ovf, tk_ud;
    logic [2:0] e_flush;
    @(negedge clk);
    id_valid = iv; id_undef = iu; id_pc = ipc;
    ex_valid = ev; ex_ovf = eo; ex_pc = epc_in;
    tk_ovf = ev && eo;
    tk_ud  = iv && iu && !tk_ovf;
    e_flush = tk_ovf ? 3'b111 : (tk_ud ? 3'b011 : 3'b000);
    #1;
    chk(flush_vec == e_flush, req, "flush_vec", 32'(flush_vec), 32'(e_flush));
    chk(wb_kill == tk_ovf, req, "wb_kill", 32'(wb_kill), 32'(tk_ovf));
    chk(redirect_valid == (tk_ovf || tk_ud), req, "redirect_valid",
        32'(redirect_valid), 32'(tk_ovf || tk_ud));
    if (tk_ovf || tk_ud)
      chk(redirect_pc == HANDLER, req, "redirect_pc", redirect_pc, HANDLER);
    if (tk_ovf) begin
      m_epc = epc_in + 32'd4; m_cause = 1'b1;
    end else if (tk_ud) begin
      m_epc = ipc + 32'd4; m_cause = 1'b0;
    end
    @(posedge clk); #1;
    chk(epc == m_epc, req, "epc", epc, m_epc);
    chk(cause == m_cause, req, "cause", 32'(cause), 32'(m_cause));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_1234;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(epc == 32'h0, "R1", "epc", epc, 32'h0);
    chk(cause == 1'b0, "R1", "cause", 32'(cause), 32'h0);
    chk(flush_vec == 3'b000 && !redirect_valid && !wb_kill, "R1", "quiet",
        32'({flush_vec, redirect_valid, wb_kill}), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 32'h0, 0, 0, 32'h0, "R1");

    // R3: undefined opcode in decode
    step(1, 1, 32'h0000_1000, 1, 0, 32'h0000_0ffc, "R3");
    // R6: hold
    step(0, 0, 32'h0, 0, 0, 32'h0, "R6");
    step(1, 0, 32'h0000_2000, 1, 0, 32'h0000_1ffc, "R6");
    // R2: overflow in execute
    step(1, 0, 32'h0000_0050, 1, 1, 32'h0000_004c, "R2");
    // R4: both at once, execute wins
    step(1, 1, 32'h0000_3004, 1, 1, 32'h0000_3000, "R4");
    step(1, 1, 32'h0000_5004, 0, 0, 32'h0000_5000, "R3");
    // R7: flags without valid
    step(0, 1, 32'h1111_1110, 0, 1, 32'h2222_2220, "R7");
    step(0, 1, 32'h3333_3330, 1, 0, 32'h4444_4440, "R7");
    // R5: wrap-around of PC plus step
    step(0, 0, 32'h0, 1, 1, 32'hFFFF_FFFC, "R5");
    step(1, 1, 32'hFFFF_FFFC, 0, 1, 32'h0, "R5");
    // back-to-back
    step(1, 1, 32'h0000_0400, 0, 0, 32'h0, "R3");
    step(0, 0, 32'h0, 1, 1, 32'h0000_0800, "R2");

    // pseudo-random mix
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[0], lfsr[1], {lfsr[31:2], 2'b00},
           lfsr[2], lfsr[3] & lfsr[4], {lfsr[29:2], 4'b0000}, "R5");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule